// File: doc/BRIEF.md
# Legacy VGA Forwarding Decoder

This block looks at a request that a processor starts, either an I/O access or a memory access, and decides whether its address falls inside the fixed legacy VGA ranges. When it does, the block names the one downstream bridge port that should take the request. Each port has two configuration bits: a VGA-enable bit and a 16-bit-decode bit. A port with 16-bit decode set claims only the two exact I/O windows in the first kilobyte of I/O space. A port with 16-bit decode clear compares only the low ten address bits, so the copies of those windows that repeat every kilobyte also match.

The result is registered. One cycle after a valid request, the block presents a one-hot port select and a hit flag. If software enables VGA on more than one port, the block routes to the lowest-numbered enabled port and sets a sticky configuration-error flag. Only reset clears that flag.

Top module: `vga_fwd_decode`

## Requirements
- R1: After reset, `port_sel` is all zero, `hit` is 0 and `cfg_err` is 0.
- R2: In 16-bit mode, an I/O request hits only when the full 16-bit address lies in 0x03B0–0x03BB or in 0x03C0–0x03DF. The three gaps 0x03AF, 0x03BC–0x03BF and 0x03E0 all miss.
- R3: In 10-bit mode, an I/O request hits when address bits [9:0] lie in 0x3B0–0x3BB or in 0x3C0–0x3DF. Bits [15:10] are ignored, so a request to 0x07B0 or 0xFFC5 hits.
- R4: A memory request (`req_is_mem`=1) hits when the address lies in 0xA0000–0xBFFFF. The decode-mode bit has no effect on memory requests.
- R5: If no port has its VGA-enable bit set, nothing hits, whatever its 16-bit-decode bit holds.
- R6: Outputs appear exactly one clock after the request is sampled. When `req_valid` is 0, `hit` is 0 and `port_sel` is zero in the next cycle.
- R7: `port_sel` is one-hot whenever `hit` is 1, and all zero when `hit` is 0.
- R8: If more than one port has VGA-enable set, a hit goes to the lowest-numbered enabled port, and that port's own decode mode applies.
- R9: `cfg_err` becomes 1 the cycle after two or more enable bits are seen set. It then stays 1 until reset, even after the enables are corrected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_mem | input | 1 | 1 = memory request, 0 = I/O request |
| req_addr | input | ADDR_W | Request address; I/O uses bits [15:0] |
| vga_en | input | NPORTS | Per-port VGA enable |
| dec16 | input | NPORTS | Per-port 16-bit decode select |
| port_sel | output | NPORTS | Registered one-hot target port |
| hit | output | 1 | Registered VGA hit |
| cfg_err | output | 1 | Sticky error: more than one port enabled |

## Verification
The assertions check on every cycle that `port_sel` is one-hot or zero and agrees with `hit`. They also check that an idle cycle produces no hit, that the error flag never falls while out of reset, and that two or more enables raise the flag one cycle later. Only the bench's scenarios can show the address details: the exact edges of the windows, the behaviour of aliases in each decode mode, the memory window, and which port wins when several are enabled. The bench covers these with a behavioural model that it compares against the outputs on every clock.

// File: rtl/vga_fwd_decode.sv
module vga_fwd_decode #(
  parameter int NPORTS = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_mem,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NPORTS-1:0] vga_en,
  input  logic [NPORTS-1:0] dec16,
  output logic [NPORTS-1:0] port_sel,
  output logic              hit,
  output logic              cfg_err
);

  localparam int CNT_W = $clog2(NPORTS + 1);

  logic [9:0]        lo10;
  logic              hi_zero;
  logic              io_win10;
  logic              mem_win;
  logic [NPORTS-1:0] owner;
  logic              use16;
  logic              match;
  logic              multi_en;

  assign lo10     = req_addr[9:0];
  assign hi_zero  = (req_addr[ADDR_W-1:10] == '0);
  assign io_win10 = (lo10 >= 10'h3B0 && lo10 <= 10'h3BB) ||
                    (lo10 >= 10'h3C0 && lo10 <= 10'h3DF);
  assign mem_win  = (req_addr >= ADDR_W'(32'hA0000)) && (req_addr <= ADDR_W'(32'hBFFFF));
  assign owner    = vga_en & (~vga_en + 1'b1);
  assign use16    = |(owner & dec16);
  assign multi_en = ($countones(vga_en) > 1);

  always_comb begin
    if (req_is_mem) match = mem_win;
    else if (use16) match = io_win10 && hi_zero;
    else            match = io_win10 && (req_addr[ADDR_W-1:16] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_sel <= '0;
      hit      <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      hit      <= req_valid && match && (owner != '0);
      port_sel <= (req_valid && match) ? owner : '0;
      if (multi_en) cfg_err <= 1'b1;
    end
  end

  logic [CNT_W-1:0] sel_cnt;
  assign sel_cnt = CNT_W'($countones(port_sel));

  assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_sel) && (hit == (sel_cnt == CNT_W'(1))));

  assert_idle_nohit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!hit && port_sel == '0));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  assert_err_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(vga_en) > 1) |=> cfg_err);

  assert_no_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vga_en == '0) |=> !hit);

endmodule

// File: tb/test_vga_fwd_decode.sv
module test_vga_fwd_decode;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int AW = 32;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_is_mem = 0;
  logic [AW-1:0] req_addr = '0;
  logic [N-1:0] vga_en = '0, dec16 = '0;
  logic [N-1:0] port_sel;
  logic hit, cfg_err;

  int total = 0, bad = 0;
  logic [N-1:0] exp_sel = '0;
  logic exp_hit = 0, exp_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vga_fwd_decode #(.NPORTS(N), .ADDR_W(AW)) i_vga_fwd_decode (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_mem(req_is_mem),
    .req_addr(req_addr), .vga_en(vga_en), .dec16(dec16),
    .port_sel(port_sel), .hit(hit), .cfg_err(cfg_err));

  function automatic bit in_io(int unsigned a);
    return (a >= 'h3B0 && a <= 'h3BB) || (a >= 'h3C0 && a <= 'h3DF);
  endfunction

  always @(posedge clk) begin
    int own;
    bit m;
    own = -1;
    for (int i = N-1; i >= 0; i--) if (vga_en[i]) own = i;
    if (!rst_n) begin
      exp_sel <= '0; exp_hit <= 0; exp_err <= 0;
    end else begin
      if (req_is_mem) m = (req_addr >= 'hA0000 && req_addr <= 'hBFFFF);
      else if (own >= 0 && dec16[own]) m = in_io(req_addr);
      else m = (req_addr < 'h10000) && in_io(req_addr % 1024);
      if (req_valid && m && own >= 0) begin
        exp_hit <= 1; exp_sel <= N'(1) << own;
      end else begin
        exp_hit <= 0; exp_sel <= '0;
      end
      if ($countones(vga_en) > 1) exp_err <= 1;
    end
  end

  task automatic chk(string tag);
    total++;
    if (port_sel !== exp_sel || hit !== exp_hit || cfg_err !== exp_err) begin
      bad++;
      $display("FAIL %s: sel=%b hit=%b err=%b exp sel=%b hit=%b err=%b addr=%h",
               tag, port_sel, hit, cfg_err, exp_sel, exp_hit, exp_err, req_addr);
    end
  endtask

  task automatic go(string tag, bit v, bit mem, logic [AW-1:0] a);
    req_valid = v; req_is_mem = mem; req_addr = a;
    @(posedge clk); #1;
    chk(tag);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; chk("R1 reset");
    if (port_sel !== 0 || hit !== 0 || cfg_err !== 0) begin
      bad++; $display("FAIL R1: sel=%b hit=%b err=%b exp 0", port_sel, hit, cfg_err);
    end
    total++;
    rst_n = 1;
    vga_en = 4'b0100; dec16 = 4'b0100;
    go("R2 lo edge", 1, 0, 'h3B0);
    go("R2 3BB", 1, 0, 'h3BB);
    go("R2 3BC gap", 1, 0, 'h3BC);
    go("R2 3AF", 1, 0, 'h3AF);
    go("R2 3DF", 1, 0, 'h3DF);
    go("R2 3E0", 1, 0, 'h3E0);
    go("R2 alias miss", 1, 0, 'h7B0);
    dec16 = 4'b1011;
    go("R3 alias 7B0", 1, 0, 'h7B0);
    go("R3 alias FFC5", 1, 0, 'hFFC5);
    go("R3 3BF", 1, 0, 'h3BF);
    go("R3 upper bits", 1, 0, 'h103C0);
    go("R4 mem lo", 1, 1, 'hA0000);
    go("R4 mem hi", 1, 1, 'hBFFFF);
    go("R4 mem over", 1, 1, 'hC0000);
    go("R4 io addr as mem", 1, 1, 'h3C0);
    dec16 = 4'b0100;
    go("R4 mem dec16", 1, 1, 'hB8000);
    go("R4 mem below", 1, 1, 'h9FFFF);
    go("R6 idle", 0, 0, 'h3C0);
    go("R6 back", 1, 0, 'h3C0);
    vga_en = 0; dec16 = 4'b1111;
    go("R5 none io", 1, 0, 'h3C0);
    go("R5 none mem", 1, 1, 'hA0000);
    vga_en = 4'b1010; dec16 = 4'b0010;
    go("R8 R9 multi lowest", 1, 0, 'h3C0);
    go("R8 owner dec16 alias", 1, 0, 'h7C0);
    vga_en = 4'b0001; dec16 = 0;
    go("R9 sticky", 1, 0, 'h7C0);
    go("R9 sticky2", 1, 1, 'hA1234);
    for (int k = 0; k < 200; k++) begin
      vga_en = N'(1) << (k % N);
      dec16 = N'(k * 7);
      go("R7 sweep", (k % 5) != 0, (k % 3) == 0,
         (k % 3 == 0) ? AW'('h9F000 + k * 'h400) : AW'('h380 + k * 3 + (k % 4) * 'h400));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule